// File: doc/BRIEF.md
# Video DRAM Random-Port Cycle Decoder

This block decodes the random-access control port of a 256K x 4 multiport video DRAM. It runs from a fast sampling clock. The active-low row strobe, column strobe and write strobe pass through two-flop synchronizers before edge detection. The levels on the other pins are sampled in the cycle where a strobe edge is detected. The pin levels at the row-strobe fall fix the kind of cycle: refresh, masked write, persistent write-per-bit, plain write, or register load. Within a write cycle, the data-function pin at each column-strobe fall chooses between a single-column write and a four-column block write.

The block holds a 4-bit write-mask register and a 4-bit color register. It emits a one-cycle command pulse to a downstream array-write datapath. Each pulse carries the command code, the write type, the row and column addresses, the column-select lanes, the data and the effective per-bit enable mask. Data is taken on whichever falls later: the write strobe or the column strobe. Several column strobes inside one row cycle (page mode) each produce their own command.

Top module: `vram_port_decoder`

## Requirements
- R1: While rst_ni is low, the write mask reads 4'hF, the color register reads 4'h0 and no command pulse is issued.
- R2: If the column strobe is already low when the row strobe falls, exactly one command with code 1 (refresh) is issued, and the rest of that row cycle is ignored, including any write-strobe fall.
- R3: row_o carries addr_i sampled at the row-strobe fall. col_o carries addr_i sampled at the column-strobe fall, with its two low bits forced to zero for block writes.
- R4: W low and DSF low at the row-strobe fall select a masked cycle (wtype 1). DQ sampled at that edge becomes bitmask_o for the cycle's writes, and the stored write mask is not changed.
- R5: W low and DSF high at the row-strobe fall select a persistent write-per-bit cycle (wtype 2). Its bitmask_o equals the stored write mask.
- R6: W high and DSF low at the row-strobe fall select a non-masked cycle (wtype 0) with bitmask_o = 4'hF.
- R7: In a write cycle, DSF low at the column-strobe fall gives command 2 (single write). That command has data_o = DQ and col_sel_o one-hot on col[1:0]. DSF high gives command 3 (block write), with data_o = color register and col_sel_o = DQ as a column mask.
- R8: W high and DSF high at the row-strobe fall select a register load, with wtype 0 and bitmask_o 0. DSF low at the column-strobe fall loads the write mask from DQ (command 4). DSF high loads the color register from DQ (command 5). Neither register changes at any other time except reset.
- R9: Write data is DQ sampled at whichever is later of the write-strobe fall and the column-strobe fall.
- R10: Each column-strobe cycle within one row cycle that sees the write strobe fall issues its own command.
- R11: A row cycle in which the write strobe never falls while the column strobe is low issues no command.
- R12: TRG low at the row-strobe fall makes the whole row cycle issue no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | sampling clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ras_ni | input | 1 | row strobe, active low |
| cas_ni | input | 1 | column strobe, active low |
| we_ni | input | 1 | write strobe / mask select, active low |
| trg_ni | input | 1 | transfer/output-enable pin, must be high for random cycles |
| dsf_i | input | 1 | special-function select |
| addr_i | input | 9 | multiplexed row/column address |
| dq_i | input | 4 | data, mask or column-mask pins |
| cmd_valid_o | output | 1 | one-cycle command strobe |
| cmd_o | output | 3 | command code (1 refresh, 2 write, 3 block, 4 load mask, 5 load color) |
| wtype_o | output | 2 | write type (0 plain, 1 masked, 2 persistent) |
| row_o | output | 9 | row address of the command |
| col_o | output | 9 | column address of the command |
| col_sel_o | output | 4 | column lanes written |
| data_o | output | 4 | data written |
| bitmask_o | output | 4 | per-bit write enable, 1 = write |
| wmask_o | output | 4 | stored write-mask register |
| color_o | output | 4 | color register |

## Verification
The bench moves DQ between the column-strobe fall and a late write-strobe fall. A decoder that latched data on the wrong edge would therefore report the complemented value. A masked cycle follows a loaded persistent mask, so a design that wrote the one-cycle mask into the stored register would show a changed wmask_o. Other cases cover the following. A refresh with a stray write-strobe fall must not emit a write. A read-only cycle and a TRG-low cycle must stay silent. Block writes must clear the low column bits and take their data from the color register. A page-mode pair must produce two commands.

// File: rtl/vram_dec_pkg.sv
package vram_dec_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_REFRESH = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_BLOCK   = 3'd3,
    CMD_LD_MASK = 3'd4,
    CMD_LD_COLOR= 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    WT_PLAIN   = 2'd0,
    WT_MASKED  = 2'd1,
    WT_PERSIST = 2'd2
  } wtype_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WRITE, ST_LOAD, ST_SKIP
  } state_e;
endpackage

// File: rtl/vram_strobe_sync.sv
module vram_strobe_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign fall_o = s3_q & ~s2_q;
  assign rise_o = ~s3_q & s2_q;
endmodule

// File: rtl/vram_color_regs.sv
module vram_color_regs #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_mask_i,
  input  logic          ld_color_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] wmask_o,
  output logic [DW-1:0] color_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wmask_o <= '1;
      color_o <= '0;
    end else begin
      if (ld_mask_i)  wmask_o <= d_i;
      if (ld_color_i) color_o <= d_i;
    end
  end
endmodule

// File: rtl/vram_port_decoder.sv
module vram_port_decoder
  import vram_dec_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          trg_ni,
  input  logic          dsf_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_o,
  output logic [1:0]    wtype_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic [DW-1:0] col_sel_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] bitmask_o,
  output logic [DW-1:0] wmask_o,
  output logic [DW-1:0] color_o
);
  localparam int BLK_W = $clog2(DW);

  logic [2:0] lvl, fall, rise;
  vram_strobe_sync #(.W(3)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({we_ni, cas_ni, ras_ni}),
    .lvl_o (lvl), .fall_o(fall), .rise_o(rise)
  );

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, cas_lvl, we_lvl;
  assign ras_fall = fall[0];
  assign ras_rise = rise[0];
  assign cas_fall = fall[1];
  assign cas_rise = rise[1];
  assign we_fall  = fall[2];
  assign cas_lvl  = lvl[1];
  assign we_lvl   = lvl[2];

  state_e          st_q;
  wtype_e          wt_q;
  logic [DW-1:0]   cyc_mask_q;
  logic [AW-1:0]   row_q, col_q;
  logic            dsf_c_q, cas_open_q;

  // column phase: data latched on the later of column and write strobe fall
  logic            in_cyc, fire;
  logic [AW-1:0]   f_col;
  logic            f_dsf;
  assign in_cyc = (st_q == ST_WRITE || st_q == ST_LOAD) && !ras_rise && !ras_fall;
  assign fire   = in_cyc && ((cas_fall && !we_lvl) ||
                             (!cas_fall && we_fall && cas_open_q));
  assign f_col  = cas_fall ? addr_i : col_q;
  assign f_dsf  = cas_fall ? dsf_i  : dsf_c_q;

  logic ld_mask, ld_color;
  assign ld_mask  = fire && (st_q == ST_LOAD) && !f_dsf;
  assign ld_color = fire && (st_q == ST_LOAD) &&  f_dsf;

  vram_color_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_mask_i(ld_mask), .ld_color_i(ld_color), .d_i(dq_i),
    .wmask_o(wmask_o), .color_o(color_o)
  );

  logic [DW-1:0] eff_mask;
  always_comb begin
    unique case (wt_q)
      WT_MASKED:  eff_mask = cyc_mask_q;
      WT_PERSIST: eff_mask = wmask_o;
      default:    eff_mask = '1;
    endcase
  end

  logic [DW-1:0] lane_1h;
  always_comb begin
    lane_1h = '0;
    lane_1h[f_col[BLK_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      wt_q        <= WT_PLAIN;
      cyc_mask_q  <= '1;
      row_q       <= '0;
      col_q       <= '0;
      dsf_c_q     <= 1'b0;
      cas_open_q  <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= CMD_NONE;
      wtype_o     <= WT_PLAIN;
      row_o       <= '0;
      col_o       <= '0;
      col_sel_o   <= '0;
      data_o      <= '0;
      bitmask_o   <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (ras_rise) begin
        st_q       <= ST_IDLE;
        cas_open_q <= 1'b0;
      end else if (ras_fall) begin
        cas_open_q <= 1'b0;
        row_q      <= addr_i;
        if (!cas_lvl) begin
          st_q        <= ST_SKIP;
          cmd_valid_o <= 1'b1;
          cmd_o       <= CMD_REFRESH;
          wtype_o     <= WT_PLAIN;
          row_o       <= addr_i;
          col_o       <= '0;
          col_sel_o   <= '0;
          data_o      <= '0;
          bitmask_o   <= '0;
        end else if (trg_ni == 1'b0) begin
          st_q <= ST_SKIP;
        end else begin
          unique case ({we_lvl, dsf_i})
            2'b00: begin st_q <= ST_WRITE; wt_q <= WT_MASKED; cyc_mask_q <= dq_i; end
            2'b01: begin st_q <= ST_WRITE; wt_q <= WT_PERSIST; end
            2'b10: begin st_q <= ST_WRITE; wt_q <= WT_PLAIN; end
            default: begin st_q <= ST_LOAD; wt_q <= WT_PLAIN; end
          endcase
        end
      end else if (in_cyc) begin
        if (cas_fall) begin
          col_q      <= addr_i;
          dsf_c_q    <= dsf_i;
          cas_open_q <= we_lvl;
        end else if (fire || cas_rise) begin
          cas_open_q <= 1'b0;
        end
        if (fire) begin
          cmd_valid_o <= 1'b1;
          row_o       <= row_q;
          if (st_q == ST_LOAD) begin
            cmd_o     <= f_dsf ? CMD_LD_COLOR : CMD_LD_MASK;
            wtype_o   <= WT_PLAIN;
            col_o     <= f_col;
            col_sel_o <= '0;
            data_o    <= dq_i;
            bitmask_o <= '0;
          end else if (f_dsf) begin
            cmd_o     <= CMD_BLOCK;
            wtype_o   <= wt_q;
            col_o     <= {f_col[AW-1:BLK_W], {BLK_W{1'b0}}};
            col_sel_o <= dq_i;
            data_o    <= color_o;
            bitmask_o <= eff_mask;
          end else begin
            cmd_o     <= CMD_WRITE;
            wtype_o   <= wt_q;
            col_o     <= f_col;
            col_sel_o <= lane_1h;
            data_o    <= dq_i;
            bitmask_o <= eff_mask;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vram_port_decoder_chk.sv
module vram_port_decoder_chk #(
  parameter int AW = 9,
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_o,
  input logic [2:0]    cmd_o,
  input logic [1:0]    wtype_o,
  input logic [AW-1:0] col_o,
  input logic [DW-1:0] data_o,
  input logic [DW-1:0] bitmask_o,
  input logic [DW-1:0] wmask_o,
  input logic [DW-1:0] color_o
);
  logic is_wr;
  assign is_wr = cmd_valid_o && (cmd_o == 3'd2 || cmd_o == 3'd3);

  a_r8_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'd4) |-> wmask_o == data_o);
  a_r8_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wmask_o) |-> (cmd_valid_o && cmd_o == 3'd4));
  a_r8_color_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(color_o) |-> (cmd_valid_o && cmd_o == 3'd5));
  a_r7_block_fmt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == 3'd3) |-> (col_o[1:0] == 2'b00 && data_o == color_o));
  a_r6_plain_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && wtype_o == 2'd0) |-> bitmask_o == '1);
  a_r5_persist_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && wtype_o == 2'd2) |-> bitmask_o == wmask_o);
  a_r1_code_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_o != 3'd0 && cmd_o <= 3'd5));
endmodule

bind vram_port_decoder vram_port_decoder_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
  .wtype_o(wtype_o), .col_o(col_o), .data_o(data_o), .bitmask_o(bitmask_o),
  .wmask_o(wmask_o), .color_o(color_o)
);

// File: tb/vram_port_decoder_test.sv
module vram_port_decoder_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, trg_ni = 1'b1, dsf_i = 1'b0;
  logic [8:0] addr_i = '0;
  logic [3:0] dq_i = '0;
  logic cmd_valid_o;
  logic [2:0] cmd_o;
  logic [1:0] wtype_o;
  logic [8:0] row_o, col_o;
  logic [3:0] col_sel_o, data_o, bitmask_o, wmask_o, color_o;

  always #4 clk = ~clk;

  vram_port_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .trg_ni(trg_ni), .dsf_i(dsf_i), .addr_i(addr_i), .dq_i(dq_i),
    .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o), .wtype_o(wtype_o), .row_o(row_o),
    .col_o(col_o), .col_sel_o(col_sel_o), .data_o(data_o), .bitmask_o(bitmask_o),
    .wmask_o(wmask_o), .color_o(color_o)
  );

  int n_chk = 0, n_fail = 0, n_pulse = 0;
  logic [2:0] l_cmd; logic [1:0] l_wt; logic [8:0] l_row, l_col;
  logic [3:0] l_sel, l_data, l_mask;

  always @(negedge clk) if (cmd_valid_o) begin
    n_pulse++;
    l_cmd = cmd_o; l_wt = wtype_o; l_row = row_o; l_col = col_o;
    l_sel = col_sel_o; l_data = data_o; l_mask = bitmask_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  typedef struct packed {
    logic we_r; logic dsf_r; logic [3:0] dq_r; logic [8:0] row;
    logic late; logic dsf_c; logic [8:0] col; logic [3:0] dq_w;
    logic [2:0] cmd; logic [1:0] wtp; logic [3:0] mask; logic [3:0] data;
    logic [3:0] sel; logic [8:0] col_x;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1,1'b1,4'h0,9'h011,1'b0,1'b1,9'h020,4'hA, 3'd5,2'd0,4'h0,4'hA,4'h0,9'h020}, // R8 color
    '{1'b1,1'b1,4'h0,9'h012,1'b1,1'b0,9'h021,4'h6, 3'd4,2'd0,4'h0,4'h6,4'h0,9'h021}, // R8 mask, R9 late
    '{1'b1,1'b0,4'h0,9'h1A5,1'b0,1'b0,9'h105,4'h3, 3'd2,2'd0,4'hF,4'h3,4'h2,9'h105}, // R6 R7
    '{1'b0,1'b1,4'h0,9'h033,1'b1,1'b0,9'h0A3,4'h9, 3'd2,2'd2,4'h6,4'h9,4'h8,9'h0A3}, // R5 R9
    '{1'b0,1'b0,4'hC,9'h044,1'b0,1'b0,9'h010,4'h5, 3'd2,2'd1,4'hC,4'h5,4'h1,9'h010}, // R4
    '{1'b0,1'b0,4'h3,9'h055,1'b0,1'b1,9'h1FF,4'hB, 3'd3,2'd1,4'h3,4'hA,4'hB,9'h1FC}, // R4 R7
    '{1'b1,1'b0,4'h0,9'h066,1'b1,1'b1,9'h046,4'h5, 3'd3,2'd0,4'hF,4'hA,4'h5,9'h044}, // R6 R7 R9
    '{1'b0,1'b1,4'h0,9'h077,1'b0,1'b1,9'h002,4'hF, 3'd3,2'd2,4'h6,4'hA,4'hF,9'h000}  // R5 R7
  };

  task automatic run_vec(input vec_t v, input string tag);
    int p0;
    p0 = n_pulse;
    addr_i = v.row; we_ni = v.we_r; dsf_i = v.dsf_r; dq_i = v.dq_r; trg_ni = 1'b1;
    wt(4); ras_ni = 1'b0; wt(5);
    we_ni = v.late; addr_i = v.col; dsf_i = v.dsf_c; dq_i = v.late ? ~v.dq_w : v.dq_w;
    wt(4); cas_ni = 1'b0; wt(5);
    if (v.late) begin dq_i = v.dq_w; wt(1); we_ni = 1'b0; wt(5); end
    else begin dq_i = ~v.dq_w; wt(4); end
    we_ni = 1'b1; cas_ni = 1'b1; wt(4); ras_ni = 1'b1; wt(5);
    chk({tag, " R11 pulses"}, n_pulse - p0, 1);
    chk({tag, " R8 cmd"}, l_cmd, v.cmd);
    chk({tag, " R4 wtype"}, l_wt, v.wtp);
    chk({tag, " R3 row"}, l_row, v.row);
    chk({tag, " R3 col"}, l_col, v.col_x);
    chk({tag, " R7 col_sel"}, l_sel, v.sel);
    chk({tag, " R9 data"}, l_data, v.data);
    chk({tag, " R5 bitmask"}, l_mask, v.mask);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    wt(3);
    chk("R1 reset wmask", wmask_o, 4'hF);
    chk("R1 reset color", color_o, 4'h0);
    chk("R1 reset no cmd", cmd_valid_o, 0);
    rst_ni = 1'b1; wt(4);

    foreach (VEC[i]) begin
      run_vec(VEC[i], $sformatf("vec%0d", i));
      if (i == 0) chk("R8 color loaded", color_o, 4'hA);
      if (i == 1) chk("R8 mask loaded", wmask_o, 4'h6);
      if (i == 4) chk("R4 stored mask kept", wmask_o, 4'h6);
    end

    // R2: refresh, stray write strobe ignored
    p0 = n_pulse; addr_i = 9'h0AB; dq_i = 4'h1; dsf_i = 1'b1;
    cas_ni = 1'b0; wt(4); ras_ni = 1'b0; wt(5); we_ni = 1'b0; wt(5);
    we_ni = 1'b1; ras_ni = 1'b1; wt(4); cas_ni = 1'b1; wt(5);
    chk("R2 one pulse", n_pulse - p0, 1);
    chk("R2 refresh code", l_cmd, 1);
    chk("R2 mask kept", wmask_o, 4'h6);
    chk("R2 color kept", color_o, 4'hA);

    // R10: page mode, two columns in one row cycle
    p0 = n_pulse; addr_i = 9'h100; we_ni = 1'b1; dsf_i = 1'b0;
    wt(4); ras_ni = 1'b0; wt(5);
    we_ni = 1'b0; addr_i = 9'h011; dq_i = 4'h7; wt(4); cas_ni = 1'b0; wt(5); cas_ni = 1'b1; wt(5);
    addr_i = 9'h012; dq_i = 4'h8; wt(4); cas_ni = 1'b0; wt(5); cas_ni = 1'b1; we_ni = 1'b1; wt(4);
    ras_ni = 1'b1; wt(5);
    chk("R10 two pulses", n_pulse - p0, 2);
    chk("R10 last col", l_col, 9'h012);
    chk("R10 last data", l_data, 4'h8);

    // R11: read-only cycle
    p0 = n_pulse; addr_i = 9'h0F0; we_ni = 1'b1; dsf_i = 1'b0;
    wt(4); ras_ni = 1'b0; wt(5); cas_ni = 1'b0; wt(5); cas_ni = 1'b1; wt(4); ras_ni = 1'b1; wt(5);
    chk("R11 read no cmd", n_pulse - p0, 0);

    // R12: TRG low at row fall
    p0 = n_pulse; trg_ni = 1'b0; we_ni = 1'b0; dsf_i = 1'b0; dq_i = 4'h0;
    wt(4); ras_ni = 1'b0; wt(5); trg_ni = 1'b1; cas_ni = 1'b0; wt(5);
    cas_ni = 1'b1; we_ni = 1'b1; wt(4); ras_ni = 1'b1; wt(5);
    chk("R12 trg low no cmd", n_pulse - p0, 0);
    chk("R12 mask kept", wmask_o, 4'h6);

    // R1: reset mid-run restores registers
    rst_ni = 1'b0; wt(2);
    chk("R1 re-reset wmask", wmask_o, 4'hF);
    chk("R1 re-reset color", color_o, 4'h0);
    rst_ni = 1'b1; wt(2);
    finish_run();
  end
endmodule